// File: doc/BRIEF.md
# Saturating Complex Twiddle Multiplier

This block rotates one complex fixed-point sample by one complex twiddle factor per clock, as needed between the stages of a pipelined FFT or IFFT. The sample parts and the twiddle parts are signed fractions: the most significant bit weighs -1 and the rest are binary fractions. The twiddle is a quantized root of unity. The block forms the four partial products at full width and adds them into a real part a·c − b·d and an imaginary part a·d + b·c. It then drops the fractional bits that the twiddle added, rounding toward negative infinity. The result goes back into the sample format.

A rotation can push a component of a large sample past the format limits. A per-sample `sat_en` input selects what happens then. With `sat_en` set, the component is clipped to the nearest extreme, so samples may use the full range. With `sat_en` clear, the component wraps in two's complement and `out_ovf` flags that sample. In that mode the sample magnitude must stay within about 0.707 to be safe. The value +1 cannot be written in the fractional format, so a unity rotation is requested with the `tw_unity` flag. The sample then passes through unchanged and no error is added.

Top module: `twd_cmul`

## Requirements
- R1: For an in-range result, out_re = floor((a·c − b·d) / 2^(TWID_W−1)) and out_im = floor((a·d + b·c) / 2^(TWID_W−1)). Here a = in_re, b = in_im, c = tw_re and d = tw_im, all read as signed two's complement integers.
- R2: Dropping the fraction rounds toward negative infinity, so a negative product with a nonzero fraction goes to the next lower integer.
- R3: With sat_en = 1, a component above 2^(DATA_W−1)−1 becomes 2^(DATA_W−1)−1. A component below −2^(DATA_W−1) becomes −2^(DATA_W−1). out_ovf stays 0.
- R4: With sat_en = 0, an out-of-range component keeps its low DATA_W bits (two's complement wrap), and out_ovf is 1 for that output sample.
- R5: With tw_unity = 1, out_re = in_re and out_im = in_im exactly. tw_re and tw_im are ignored, and out_ovf is 0 whatever sat_en is.
- R6: Results appear exactly two clock edges after the inputs are sampled. out_valid repeats in_valid with the same delay, and one new sample is accepted on every clock.
- R7: While rst_n is low, out_valid, out_ovf, out_re and out_im are all 0.
- R8: out_ovf is never 1 while out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input sample is valid |
| in_re | input | DATA_W | Sample real part, signed fraction |
| in_im | input | DATA_W | Sample imaginary part, signed fraction |
| tw_re | input | TWID_W | Twiddle real part, signed fraction |
| tw_im | input | TWID_W | Twiddle imaginary part, signed fraction |
| tw_unity | input | 1 | Treat the twiddle as exactly +1 (bypass) |
| sat_en | input | 1 | 1 = clip out-of-range results, 0 = wrap them |
| out_valid | output | 1 | Output sample is valid |
| out_re | output | DATA_W | Rotated real part |
| out_im | output | DATA_W | Rotated imaginary part |
| out_ovf | output | 1 | A component wrapped in this sample |

## Verification
Samples inside the 0.707 radius under 45° and 90° twiddles test the sum signs and the lane pairing. Positive and negative samples with a fraction left over separate flooring from rounding toward zero. Full-scale samples, together with the −1·−1 product, overflow in both directions. Each of these runs once with clipping and once with wrapping, which separates the two range policies and the flag. Unity requests with unrelated twiddle values and extreme samples show that the bypass passes the sample exactly, and streaming the vectors back to back checks latency and throughput.

// File: rtl/twd_cmul_pkg.sv
package twd_cmul_pkg;
   // lane index inside the rotation datapath
   typedef enum logic {
      LANE_RE = 1'b0,
      LANE_IM = 1'b1
   } cmul_lane_e;

   localparam int NUM_LANES = 2;
endpackage

// File: rtl/twd_cmul_lane.sv
// One output component: two registered products, then a combinational
// sum or difference with the twiddle fraction bits dropped (floor).
module twd_cmul_lane #(
   parameter int DATA_W = 12,
   parameter int TWID_W = 12,
   parameter bit SUBTRACT = 1'b0,
   localparam int PW = DATA_W + TWID_W,
   localparam int SW = PW + 1,
   localparam int SH = TWID_W - 1,
   localparam int RW = SW - SH
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [DATA_W-1:0] x0,
   input  logic signed [TWID_W-1:0] y0,
   input  logic signed [DATA_W-1:0] x1,
   input  logic signed [TWID_W-1:0] y1,
   output logic signed [RW-1:0]     sum_floor
);
   logic signed [PW-1:0] prod0_q;
   logic signed [PW-1:0] prod1_q;
   logic signed [SW-1:0] sum_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod0_q <= '0;
         prod1_q <= '0;
      end else begin
         prod0_q <= PW'(x0) * PW'(y0);
         prod1_q <= PW'(x1) * PW'(y1);
      end
   end

   generate
      if (SUBTRACT) begin : g_diff
         always_comb sum_full = SW'(prod0_q) - SW'(prod1_q);
      end else begin : g_add
         always_comb sum_full = SW'(prod0_q) + SW'(prod1_q);
      end
   endgenerate

   // dropping the low bits of a two's complement value floors it
   assign sum_floor = sum_full[SW-1:SH];
endmodule

// File: rtl/twd_cmul_fit.sv
// Brings a widened component back into DATA_W bits by clipping or wrapping.
module twd_cmul_fit #(
   parameter int DATA_W = 12,
   parameter int IN_W = 14
) (
   input  logic signed [IN_W-1:0]   v,
   input  logic                     clip,
   output logic signed [DATA_W-1:0] y,
   output logic                     wrapped
);
   localparam logic signed [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic signed [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

   logic [IN_W-DATA_W:0] top_bits;
   logic                 in_range;

   assign top_bits = v[IN_W-1:DATA_W-1];
   assign in_range = (&top_bits) | ~(|top_bits);

   always_comb begin
      y       = v[DATA_W-1:0];
      wrapped = 1'b0;
      if (!in_range) begin
         if (clip) y = v[IN_W-1] ? NEG_MIN : POS_MAX;
         else      wrapped = 1'b1;
      end
   end
endmodule

// File: rtl/twd_cmul.sv
module twd_cmul
   import twd_cmul_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int TWID_W = 12,
   localparam int PW = DATA_W + TWID_W,
   localparam int RW = PW + 1 - (TWID_W - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_re,
   input  logic [DATA_W-1:0] in_im,
   input  logic [TWID_W-1:0] tw_re,
   input  logic [TWID_W-1:0] tw_im,
   input  logic              tw_unity,
   input  logic              sat_en,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_re,
   output logic [DATA_W-1:0] out_im,
   output logic              out_ovf
);
   initial begin
      assert (DATA_W >= 4 && DATA_W <= 32) else $error("DATA_W out of range");
      assert (TWID_W >= 4 && TWID_W <= 32) else $error("TWID_W out of range");
   end

   // stage 1 side band: bypass sample and controls
   logic              vld_s1, unity_s1, sat_s1;
   logic [DATA_W-1:0] re_s1, im_s1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_s1   <= 1'b0;
         unity_s1 <= 1'b0;
         sat_s1   <= 1'b0;
         re_s1    <= '0;
         im_s1    <= '0;
      end else begin
         vld_s1   <= in_valid;
         unity_s1 <= tw_unity;
         sat_s1   <= sat_en;
         re_s1    <= in_re;
         im_s1    <= in_im;
      end
   end

   logic signed [DATA_W-1:0] fit_y   [NUM_LANES];
   logic                     fit_wrap[NUM_LANES];

   generate
      for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
         localparam bit IS_RE = (g == int'(LANE_RE));
         logic signed [RW-1:0] floor_v;

         twd_cmul_lane #(
            .DATA_W  (DATA_W),
            .TWID_W  (TWID_W),
            .SUBTRACT(IS_RE)
         ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .x0       ($signed(in_re)),
            .y0       (IS_RE ? $signed(tw_re) : $signed(tw_im)),
            .x1       ($signed(in_im)),
            .y1       (IS_RE ? $signed(tw_im) : $signed(tw_re)),
            .sum_floor(floor_v)
         );

         twd_cmul_fit #(
            .DATA_W(DATA_W),
            .IN_W  (RW)
         ) u_fit (
            .v      (floor_v),
            .clip   (sat_s1),
            .y      (fit_y[g]),
            .wrapped(fit_wrap[g])
         );
      end
   endgenerate

   // stage 2: output register, unity selects the untouched sample
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_re    <= '0;
         out_im    <= '0;
         out_ovf   <= 1'b0;
      end else begin
         out_valid <= vld_s1;
         if (unity_s1) begin
            out_re  <= re_s1;
            out_im  <= im_s1;
            out_ovf <= 1'b0;
         end else begin
            out_re  <= fit_y[int'(LANE_RE)];
            out_im  <= fit_y[int'(LANE_IM)];
            out_ovf <= vld_s1 & (fit_wrap[int'(LANE_RE)] | fit_wrap[int'(LANE_IM)]);
         end
      end
   end
endmodule

// File: rtl/twd_cmul_chk.sv
module twd_cmul_chk #(
   parameter int DATA_W = 12,
   parameter int TWID_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_re,
   input logic [DATA_W-1:0] in_im,
   input logic [TWID_W-1:0] tw_re,
   input logic [TWID_W-1:0] tw_im,
   input logic              tw_unity,
   input logic              sat_en,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_re,
   input logic [DATA_W-1:0] out_im,
   input logic              out_ovf
);
   // cycles since reset release, saturating at 2
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= '0;
      else if (age != 2'd2) age <= age + 2'd1;
   end

   assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

   assert_unity_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((age == 2'd2) && $past(in_valid & tw_unity, 2)) |->
         (out_re == $past(in_re, 2) && out_im == $past(in_im, 2) && !out_ovf));

   assert_clip_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((age == 2'd2) && $past(sat_en, 2)) |-> !out_ovf);

   assert_flag_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovf |-> out_valid);

   always @(posedge clk) begin
      if (!rst_n) assert_reset_idle_R7: assert (!out_valid && !out_ovf);
   end
endmodule

bind twd_cmul twd_cmul_chk #(.DATA_W(DATA_W), .TWID_W(TWID_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
   .tw_re(tw_re), .tw_im(tw_im), .tw_unity(tw_unity), .sat_en(sat_en),
   .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .out_ovf(out_ovf)
);

// File: tb/twd_cmul_tb.sv
module twd_cmul_tb;
   localparam int DW = 12;
   localparam int TW = 12;
   localparam int VW = 4 * 12 + 2;
   localparam int NV = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_re = '0, in_im = '0;
   logic [TW-1:0] tw_re = '0, tw_im = '0;
   logic          tw_unity = 1'b0, sat_en = 1'b0;
   logic          out_valid;
   logic [DW-1:0] out_re, out_im;
   logic          out_ovf;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   twd_cmul #(.DATA_W(DW), .TWID_W(TW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
      .tw_re(tw_re), .tw_im(tw_im), .tw_unity(tw_unity), .sat_en(sat_en),
      .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .out_ovf(out_ovf)
   );

   // fields: a[49:38] b[37:26] c[25:14] d[13:2] unity[1] sat[0]
   function automatic logic [VW-1:0] mk(int a, int b, int c, int d, bit u, bit s);
      return {a[11:0], b[11:0], c[11:0], d[11:0], u, s};
   endfunction

   localparam logic [VW-1:0] VEC [NV] = '{
      mk( 1024,     0,  2047,     0, 0, 0),  // R1 plain scale
      mk(-1024,     0,  2047,     0, 0, 0),  // R2 negative floor
      mk( 1000,   500,     0,  2047, 0, 0),  // R1 quarter turn
      mk( 2047,  2047,  1448, -1448, 0, 1),  // R3 high clip
      mk( 2047,  2047,  1448, -1448, 0, 0),  // R4 wrap
      mk(-2048,     0, -2048,     0, 0, 1),  // R3 minus one squared
      mk(-2048,     0, -2048,     0, 0, 0),  // R4 minus one squared
      mk(-2048,  2047,   123,   -77, 1, 0),  // R5 bypass, wrap mode
      mk( 2047, -2048, -2048, -2048, 1, 1),  // R5 bypass, clip mode
      mk( 1400,  1400,  1448, -1448, 0, 0),  // R1 safe radius
      mk(-2048, -2048,  1448,  1448, 0, 1),  // R3 low clip
      mk(-2048, -2048,  1448,  1448, 0, 0)   // R4 low wrap
   };

   typedef struct {
      int re; int im; bit ovf;
   } exp_t;

   function automatic int sx(logic [11:0] v);
      return int'($signed(v));
   endfunction

   // component model: floor, then clip or wrap
   function automatic int fit(int v, bit s, ref bit o);
      if (v > 2047 || v < -2048) begin
         if (s) return (v > 0) ? 2047 : -2048;
         o = 1'b1;
         v = v & 4095;
         return (v >= 2048) ? v - 4096 : v;
      end
      return v;
   endfunction

   function automatic exp_t model(logic [VW-1:0] e);
      exp_t r;
      int a, b, c, d;
      bit o;
      a = sx(e[49:38]); b = sx(e[37:26]); c = sx(e[25:14]); d = sx(e[13:2]);
      o = 1'b0;
      if (e[1]) begin
         r.re = a; r.im = b;
      end else begin
         r.re = fit((a * c - b * d) >>> (TW - 1), e[0], o);
         r.im = fit((a * d + b * c) >>> (TW - 1), e[0], o);
      end
      r.ovf = o;
      return r;
   endfunction

   task automatic chk(string req, int act, int exp_v);
      checks++;
      if (act != exp_v) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   task automatic drive(logic [VW-1:0] e, bit v);
      in_valid = v;
      in_re = e[49:38]; in_im = e[37:26];
      tw_re = e[25:14]; tw_im = e[13:2];
      tw_unity = e[1];  sat_en = e[0];
   endtask

   task automatic check_vec(int i);
      exp_t x;
      string tag;
      x = model(VEC[i]);
      if (VEC[i][1])     tag = "R5";
      else if (x.ovf)    tag = "R4";
      else if (VEC[i][0] && (i == 3 || i == 5 || i == 10)) tag = "R3";
      else if (i == 1)   tag = "R2";
      else               tag = "R1";
      chk({tag, " re"}, sx(out_re), x.re);
      chk({tag, " im"}, sx(out_im), x.im);
      chk({tag, " ovf"}, int'(out_ovf), int'(x.ovf));
      chk("R6 valid", int'(out_valid), 1);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R7: reset state
      chk("R7 valid", int'(out_valid), 0);
      chk("R7 ovf", int'(out_ovf), 0);
      chk("R7 re", int'(out_re), 0);
      chk("R7 im", int'(out_im), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // streaming walk of the table, one sample per clock (R6)
      for (int i = 0; i < NV + 2; i++) begin
         if (i >= 2) check_vec(i - 2);
         if (i < NV) drive(VEC[i], 1'b1);
         else        drive('0, 1'b0);
         @(negedge clk);
      end
      chk("R6 drain", int'(out_valid), 0);

      // R8: overflowing twiddle with no valid sample raises no flag
      drive(VEC[4], 1'b0);
      @(negedge clk);
      drive('0, 1'b0);
      @(negedge clk);
      chk("R8 valid", int'(out_valid), 0);
      chk("R8 ovf", int'(out_ovf), 0);

      // R6: gap between samples keeps alignment
      drive(VEC[0], 1'b1);
      @(negedge clk);
      drive('0, 1'b0);
      @(negedge clk);
      chk("R6 gap valid", int'(out_valid), 1);
      chk("R6 gap re", sx(out_re), 1023);
      @(negedge clk);
      chk("R6 gap idle", int'(out_valid), 0);

      // R7: reset while a sample is in flight
      drive(VEC[6], 1'b1);
      @(negedge clk);
      drive(VEC[6], 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R7 midflight valid", int'(out_valid), 0);
      chk("R7 midflight ovf", int'(out_ovf), 0);
      chk("R7 midflight re", int'(out_re), 0);
      drive('0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R7 after release", int'(out_valid), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule